// File: doc/BRIEF.md
# Conversion Mode and Ready Controller

This block sequences the conversions of a slow measurement converter. It runs on the system clock and advances its timing on a one-cycle timebase strobe, nominally 32.768 kHz, which gives a period of about 30.5 µs. A latched mode byte selects continuous conversion, one conversion followed by shutdown, or power-down. At the end of each output period the block takes the signed raw result from the modulator model and converts it to offset-binary or straight-binary code. A result that is out of range is clamped, and the block then writes the code to the data register.

The block keeps a ready flag that is low while an unread result is waiting. It also assembles a status byte holding the ready flag, an error flag, a width indicator and the selected channel. Software-side logic reports the events to the block: a mode register write, a data register read and a change of the channel field. The length of the output period and the warning interval before an update are parameters counted in timebase ticks. A single parameter sets the data width to 16 or 24 bits.

Top module: `conv_ready_ctrl`

## Requirements
- R1: Out of reset the data register is all zeros, the ready output is 1, the status byte is 0x88 at 16 bits (0x8C at 24 bits), and continuous mode is active.
- R2: The mode field is bits [7:6] of the mode byte, latched on a mode write. 00 is continuous, 10 is single and 11 is power-down. The reserved code 01 acts as power-down. In power-down no result is written, whatever the number of ticks.
- R3: After a start or restart the first result is written on the 2·PERIOD_TICKS-th tick. In continuous mode each later result follows every PERIOD_TICKS ticks.
- R4: In single mode exactly one result is written, after 2·PERIOD_TICKS ticks. The block then stops, and both the data register and the low ready level hold through any number of further ticks.
- R5: Writing a result drives the ready output to 0.
- R6: A data register read sets ready to 1 and leaves the data unchanged. In continuous mode ready also sets GUARD_TICKS ticks before the next result is written.
- R7: A mode write sets ready to 1 and restarts the period count. So does a change of the channel field while converting, and the status channel bits follow the new channel.
- R8: The status byte is {ready, error, 0, 0, 1, width (1 when DATA_W is 24), channel[1:0]}.
- R9: Bit 2 of the mode byte selects the coding. At 1 (unipolar) the code equals the raw value. At 0 (bipolar) the code is raw + 2^(DATA_W-1), so raw 0 gives 0x8000 at 16 bits.
- R10: A code below zero, a code above all ones, or an asserted overrange input clamps the result. With overrange it clamps to zeros for a negative raw value and to all ones otherwise. Each clamp sets the error bit (status bit 6) together with the result, and a mode write that starts a conversion clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase strobe |
| mode_wr_i | input | 1 | Mode byte write strobe |
| mode_i | input | 8 | Mode byte; [7:6] mode, [2] unipolar |
| chan_i | input | 2 | Selected channel field |
| data_rd_i | input | 1 | Data register read strobe |
| raw_i | input | DATA_W+1 | Signed raw result from modulator model |
| ovr_i | input | 1 | Modulator overrange flag |
| data_o | output | DATA_W | Data register |
| status_o | output | 8 | Status byte |
| rdy_o | output | 1 | Ready flag, low when a fresh result waits |

## Verification
Several properties are checked on every cycle. Writing a result drops ready, and a mode write or a qualifying read raises it. The data register changes only on a result write. A single-shot stops after its one result, the period counter wraps after each update, and a clamped code is all zeros or all ones. Other behaviour shows only in the bench's scenarios: the exact tick on which the first and later results land, the guard interval, power-down and the reserved mode producing nothing, and the restart on a channel change. The bench also checks the code values produced by each coding and clamp case.

// File: rtl/conv_ctrl_pkg.sv
// Shared definitions for the conversion controller.
// Assumes the mode field occupies bits [7:6] of the mode byte.
package conv_ctrl_pkg;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_RSVD   = 2'b01,
        MD_SINGLE = 2'b10,
        MD_PDOWN  = 2'b11
    } conv_mode_e;

    // True for mode codes that start a conversion run.
    function automatic logic mode_runs(conv_mode_e m);
        return (m == MD_CONT) || (m == MD_SINGLE);
    endfunction

endpackage

// File: rtl/conv_period_timer.sv
// Period timer: counts timebase ticks within an output period and
// emits the result-update and pre-update guard pulses.
// Assumes 1 <= GUARD_TICKS < PERIOD_TICKS and PERIOD_TICKS >= 2.
module conv_period_timer #(
    parameter int PERIOD_TICKS = 1966,
    parameter int GUARD_TICKS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    input  logic single_i,
    input  logic stop_i,
    input  logic restart_i,
    output logic upd_o,
    output logic guard_o,
    output logic run_o
);
    localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CW-1:0] LAST     = CW'(PERIOD_TICKS - 1);
    localparam logic [CW-1:0] GUARD_AT = CW'(PERIOD_TICKS - 1 - GUARD_TICKS);

    logic [CW-1:0] cnt_q;
    logic [1:0]    left_q;
    logic          run_q;
    logic          single_q;
    logic          quiet;

    // No control event this cycle, so a tick may advance the period.
    assign quiet   = !start_i && !stop_i && !(restart_i && run_q);
    assign upd_o   = run_q && tick_i && quiet && (cnt_q == LAST) && (left_q == 2'd1);
    assign guard_o = run_q && tick_i && quiet && (cnt_q == GUARD_AT) && (left_q == 2'd1);
    assign run_o   = run_q;

    // Advance tick count and periods-left; start, stop and restart override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b1;
            single_q <= 1'b0;
            cnt_q    <= '0;
            left_q   <= 2'd2;
        end else if (start_i) begin
            run_q    <= 1'b1;
            single_q <= single_i;
            cnt_q    <= '0;
            left_q   <= 2'd2;
        end else if (stop_i) begin
            run_q    <= 1'b0;
            cnt_q    <= '0;
            left_q   <= 2'd2;
        end else if (restart_i && run_q) begin
            cnt_q    <= '0;
            left_q   <= 2'd2;
        end else if (run_q && tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                if (left_q == 2'd2) begin
                    left_q <= 2'd1;
                end else if (single_q) begin
                    run_q  <= 1'b0;
                    left_q <= 2'd2;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // A single-shot run stops right after its one result.
    p_single_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && single_q) |=> !run_q);

    // The period count restarts from zero after each result update (R3).
    p_wrap_after_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> (cnt_q == '0));

endmodule

// File: rtl/conv_coder.sv
// Result coder: maps a signed raw result to unipolar or offset-binary
// code and clamps out-of-range or overrange values, flagging an error.
// Assumes raw_i is DATA_W+1 bits two's complement.
module conv_coder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W:0]   raw_i,
    input  logic              ovr_i,
    input  logic              uni_i,
    output logic [DATA_W-1:0] code_o,
    output logic              err_o
);
    localparam int SW = DATA_W + 2;
    localparam logic [SW-1:0] MID = {{(SW-DATA_W){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};

    logic [SW-1:0] sum;

    // Offset, range-check and clamp the raw value.
    always_comb begin
        sum = {raw_i[DATA_W], raw_i} + (uni_i ? '0 : MID);
        if (ovr_i) begin
            err_o  = 1'b1;
            code_o = raw_i[DATA_W] ? '0 : '1;
        end else if (sum[SW-1]) begin
            err_o  = 1'b1;
            code_o = '0;
        end else if (sum[DATA_W]) begin
            err_o  = 1'b1;
            code_o = '1;
        end else begin
            err_o  = 1'b0;
            code_o = sum[DATA_W-1:0];
        end
    end

    // A flagged result must be one of the two clamp codes.
    always_comb begin
        if (err_o) begin
            p_clamp_code_r10: assert ((code_o == '0) || (&code_o));
        end
    end

endmodule

// File: rtl/conv_ready_ctrl.sv
// Conversion mode and ready controller: decodes the mode byte, owns the
// data register, ready and error flags and assembles the status byte.
// Assumes strobes are one clock wide and synchronous to clk.
module conv_ready_ctrl #(
    parameter int DATA_W       = 16,
    parameter int PERIOD_TICKS = 1966,
    parameter int GUARD_TICKS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              mode_wr_i,
    input  logic [7:0]        mode_i,
    input  logic [1:0]        chan_i,
    input  logic              data_rd_i,
    input  logic [DATA_W:0]   raw_i,
    input  logic              ovr_i,
    output logic [DATA_W-1:0] data_o,
    output logic [7:0]        status_o,
    output logic              rdy_o
);
    import conv_ctrl_pkg::*;

    localparam logic WIDE = (DATA_W == 24);

    conv_mode_e        md;
    logic              starts;
    logic              chan_chg;
    logic              upd, guard, run;
    logic [DATA_W-1:0] code;
    logic              code_err;
    logic [DATA_W-1:0] data_q;
    logic              rdy_q, err_q, uni_q;
    logic [1:0]        chan_q;
    logic              unused_mode_bits;

    assign md               = conv_mode_e'(mode_i[7:6]);
    assign starts           = mode_runs(md);
    assign chan_chg         = (chan_i != chan_q);
    assign unused_mode_bits = ^{mode_i[5:3], mode_i[1:0]};

    conv_period_timer #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .GUARD_TICKS  (GUARD_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .start_i   (mode_wr_i && starts),
        .single_i  (md == MD_SINGLE),
        .stop_i    (mode_wr_i && !starts),
        .restart_i (chan_chg),
        .upd_o     (upd),
        .guard_o   (guard),
        .run_o     (run)
    );

    conv_coder #(.DATA_W(DATA_W)) u_coder (
        .raw_i  (raw_i),
        .ovr_i  (ovr_i),
        .uni_i  (uni_q),
        .code_o (code),
        .err_o  (code_err)
    );

    // Latch the coding select and track the channel being converted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uni_q  <= 1'b0;
            chan_q <= 2'b00;
        end else begin
            chan_q <= chan_i;
            if (mode_wr_i) uni_q <= mode_i[2];
        end
    end

    // Store the coded result and its error flag at each update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (upd) data_q <= code;
            if (mode_wr_i && starts) err_q <= 1'b0;
            else if (upd)            err_q <= code_err;
        end
    end

    // Ready flag: restart events set it, a result clears it, read or guard set it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= 1'b1;
        end else if (mode_wr_i || (chan_chg && run)) begin
            rdy_q <= 1'b1;
        end else if (upd) begin
            rdy_q <= 1'b0;
        end else if (data_rd_i || guard) begin
            rdy_q <= 1'b1;
        end
    end

    assign data_o   = data_q;
    assign rdy_o    = rdy_q;
    assign status_o = {rdy_q, err_q, 2'b00, 1'b1, WIDE, chan_q};

    p_update_clears_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !rdy_q);

    p_mode_wr_sets_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_i |=> rdy_q);

    p_read_sets_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd_i && !upd && !mode_wr_i) |=> rdy_q);

    p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(data_q));

endmodule

// File: tb/conv_ready_ctrl_test.sv
module conv_ready_ctrl_test;
    localparam int W = 16;
    localparam int P = 8;
    localparam int G = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         mode_wr_i = 1'b0;
    logic [7:0]   mode_i = 8'h00;
    logic [1:0]   chan_i = 2'b00;
    logic         data_rd_i = 1'b0;
    logic [W:0]   raw_i = '0;
    logic         ovr_i = 1'b0;
    logic [W-1:0] data_o;
    logic [7:0]   status_o;
    logic         rdy_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    conv_ready_ctrl #(.DATA_W(W), .PERIOD_TICKS(P), .GUARD_TICKS(G)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_wr_i(mode_wr_i),
        .mode_i(mode_i), .chan_i(chan_i), .data_rd_i(data_rd_i),
        .raw_i(raw_i), .ovr_i(ovr_i), .data_o(data_o),
        .status_o(status_o), .rdy_o(rdy_o)
    );

    // {uni, ovr, raw[16:0], code[15:0], err}
    localparam int NV = 12;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b0, 17'h00000, 16'h8000, 1'b0},
        {1'b0, 1'b0, 17'h18000, 16'h0000, 1'b0},
        {1'b0, 1'b0, 17'h07FFF, 16'hFFFF, 1'b0},
        {1'b0, 1'b0, 17'h08000, 16'hFFFF, 1'b1},
        {1'b0, 1'b0, 17'h17FFF, 16'h0000, 1'b1},
        {1'b0, 1'b1, 17'h00064, 16'hFFFF, 1'b1},
        {1'b0, 1'b1, 17'h1FFFB, 16'h0000, 1'b1},
        {1'b1, 1'b0, 17'h00000, 16'h0000, 1'b0},
        {1'b1, 1'b0, 17'h0FFFF, 16'hFFFF, 1'b0},
        {1'b1, 1'b0, 17'h004D2, 16'h04D2, 1'b0},
        {1'b1, 1'b0, 17'h1FFFF, 16'h0000, 1'b1},
        {1'b1, 1'b1, 17'h0000A, 16'hFFFF, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic write_mode(input logic [7:0] m);
        @(negedge clk) begin mode_i = m; mode_wr_i = 1'b1; end
        @(negedge clk) mode_wr_i = 1'b0;
    endtask

    task automatic read_data();
        @(negedge clk) data_rd_i = 1'b1;
        @(negedge clk) data_rd_i = 1'b0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 data", 32'(data_o), 32'h0);
        check("R1 status", 32'(status_o), 32'h88);
        check("R1 rdy", 32'(rdy_o), 32'h1);

        // R9 / R10: coding and clamp vectors
        for (int v = 0; v < NV; v++) begin
            logic [35:0] e;
            e = VEC[v];
            @(negedge clk) begin raw_i = e[33:17]; ovr_i = e[34]; end
            write_mode({2'b00, 3'b000, e[35], 2'b10});
            check("R10 err cleared by start", 32'(status_o[6]), 32'h0);
            ticks(2 * P);
            check("R9 code", 32'(data_o), 32'(e[16:1]));
            check("R10 err", 32'(status_o[6]), 32'(e[0]));
            check("R5 rdy low", 32'(rdy_o), 32'h0);
        end
        @(negedge clk) ovr_i = 1'b0;

        // R3 / R5 / R6 / R8: continuous timing
        @(negedge clk) raw_i = 17'd100;
        write_mode(8'h02);
        ticks(2 * P - 1);
        check("R3 not before 2P", 32'(rdy_o), 32'h1);
        ticks(1);
        check("R3 first result", 32'(data_o), 32'h8064);
        check("R8 status", 32'(status_o), 32'h08);
        @(negedge clk) raw_i = 17'd200;
        ticks(P - G - 1);
        check("R6 before guard", 32'(rdy_o), 32'h0);
        ticks(1);
        check("R6 guard sets rdy", 32'(rdy_o), 32'h1);
        check("R6 data held", 32'(data_o), 32'h8064);
        ticks(G);
        check("R3 next result", 32'(data_o), 32'h80C8);
        check("R5 rdy low", 32'(rdy_o), 32'h0);

        // R7: channel change restarts
        ticks(2);
        @(negedge clk) chan_i = 2'b11;
        @(negedge clk);
        check("R7 chan sets rdy", 32'(rdy_o), 32'h1);
        check("R8 chan bits", 32'(status_o[1:0]), 32'h3);
        @(negedge clk) raw_i = 17'd300;
        ticks(2 * P - 1);
        check("R7 no early result", 32'(data_o), 32'h80C8);
        ticks(1);
        check("R7 result after restart", 32'(data_o), 32'h812C);

        // R6: read sets ready, data kept
        read_data();
        check("R6 read sets rdy", 32'(rdy_o), 32'h1);
        check("R6 read keeps data", 32'(data_o), 32'h812C);

        // R2 / R7: power-down
        write_mode(8'hC2);
        check("R7 pdown rdy", 32'(rdy_o), 32'h1);
        @(negedge clk) raw_i = 17'd400;
        ticks(3 * P);
        check("R2 pdown no result", 32'(data_o), 32'h812C);
        check("R2 pdown rdy", 32'(rdy_o), 32'h1);

        // R4: single conversion
        @(negedge clk) raw_i = 17'd500;
        write_mode(8'h82);
        ticks(2 * P);
        check("R4 single result", 32'(data_o), 32'h81F4);
        check("R4 single rdy", 32'(rdy_o), 32'h0);
        @(negedge clk) raw_i = 17'd600;
        ticks(3 * P);
        check("R4 single holds data", 32'(data_o), 32'h81F4);
        check("R4 single holds rdy", 32'(rdy_o), 32'h0);

        // R2 / R7: reserved mode acts as power-down
        write_mode(8'h42);
        check("R7 mode wr sets rdy", 32'(rdy_o), 32'h1);
        ticks(3 * P);
        check("R2 reserved no result", 32'(data_o), 32'h81F4);
        check("R2 reserved rdy", 32'(rdy_o), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule